// File: doc/BRIEF.md
# Serial Engine Run-State Controller

This block holds the operating state of a serial peripheral core: held in reset, running, or paused. Software asks for a new state through a write strobe with a two-bit code. The block does not apply the request at once. It lowers its valid flag and applies the new state only after a fixed latency. That latency models a hand-over of three bus-clock cycles followed by three core-clock cycles, with the core clock a parameterised fraction of the bus clock. Software waits for the valid flag to return before it trusts the state or sends another request.

From the current state the block derives two engine controls. One lets the serial engine accept new entries. The other lets it keep shifting. In pause, the engine stops taking entries but may finish the byte it is shifting, so the queues can be refilled safely. The block also provides:
- a self-clearing software reset that flushes the queues;
- a sticky master-ready indication;
- a bank of core error flags that software clears by writing 1;
- a pulse that clears any pending bus-error condition whenever the reset state is requested;
- a count of the state requests it refused.

Top module: `runstate_ctrl`

## Requirements
- R1: After reset the state is reset (code 0), valid is 1, master-ready is 0, all error flags are 0, the refused count is 0 and both engine controls are 0.
- R2: A request with a legal code (0 = reset, 1 = run, 3 = pause) written while valid is 1 is accepted, and valid reads 0 in the cycle after the accepting edge.
- R3: Valid stays 0 for exactly SYNC_BUS + SYNC_CORE*CORE_RATIO cycles (9 by default). It then returns to 1 together with the new state, and the state does not change while valid is 0.
- R4: Master-ready becomes 1 the cycle after a configuration-done pulse and stays 1 until software reset.
- R5: Software reset, in the cycle after it is sampled, gives state 0 with valid 1, clears the error flags, master-ready and the refused count, aborts any pending request, and raises the queue-flush output for one cycle.
- R6: Error events set flags in bits 6:2 of the error word (bits 1:0 read 0). A clear write removes each flag whose data bit is 1. An event arriving in the same cycle as its clear leaves the flag set.
- R7: Take-enable is 1 only in run. Shift-enable is 1 in run, and in pause only while the engine reports a byte in progress.
- R8: A request written while valid is 0, or carrying the illegal code 2, is refused and leaves the state and valid unchanged. The refused count then rises by one.
- R9: An accepted request for the reset state raises the bus-error-clear output for one cycle, in the cycle after the accepting edge. Other requests do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrState | input | 1 | State request write strobe |
| wrCode | input | 2 | Requested state code |
| swReset | input | 1 | Software reset write strobe |
| cfgDone | input | 1 | Core configured as master (pulse) |
| errSet | input | ERR_W | Core error events |
| errClrWe | input | 1 | Error clear write strobe |
| errClrData | input | ERR_W | Error clear mask, 1 clears |
| byteBusy | input | 1 | Engine is shifting a byte |
| stateStatus | output | 5 | {master-ready, 0, valid, state[1:0]} |
| errStatus | output | ERR_W+2 | Error flags in bits ERR_W+1:2 |
| ignCount | output | IGN_W | Saturating count of refused requests |
| takeEn | output | 1 | Engine may take new entries |
| shiftEn | output | 1 | Engine may shift |
| queueFlush | output | 1 | One-cycle queue flush pulse |
| busErrClr | output | 1 | One-cycle bus-error clear pulse |

## Verification
The per-cycle properties check several rules: valid falls after every accepted request, the state holds while valid is low, the low window always lasts the computed latency, master-ready stays sticky, the software-reset outcome holds, and clear writes remove flags. The scenarios alone show the rest: which requests are refused and counted, the pause hand-off where shifting continues only while a byte is in progress, set-over-clear priority, and the bus-error-clear pulse following only reset requests.

// File: rtl/runstate_pkg.sv
package runstate_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd3
  } runState_e;

  typedef struct packed {
    logic      ignore;
    logic      commit;
    runState_e newState;
    logic      swRst;
    logic      clrBusErr;
  } ctlStrobes_t;
endpackage

// File: rtl/runstate_ctl.sv
module runstate_ctl
  import runstate_pkg::*;
#(
  parameter int SYNC_BUS   = 3,
  parameter int SYNC_CORE  = 3,
  parameter int CORE_RATIO = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrState,
  input  logic [1:0]  wrCode,
  input  logic        swReset,
  output logic        validOut,
  output ctlStrobes_t strobes
);
  localparam int LAT   = SYNC_BUS + SYNC_CORE * CORE_RATIO;
  localparam int CNT_W = $clog2(LAT + 1);

  logic             validQ;
  logic [CNT_W-1:0] waitCnt;
  runState_e        pendState;
  logic             legalCode;
  logic             accept;

  assign legalCode = (wrCode != 2'b10);
  assign accept    = wrState && validQ && legalCode && !swReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ    <= 1'b1;
      waitCnt   <= '0;
      pendState <= ST_RESET;
    end else if (swReset) begin
      validQ    <= 1'b1;
      waitCnt   <= '0;
      pendState <= ST_RESET;
    end else if (accept) begin
      validQ    <= 1'b0;
      waitCnt   <= CNT_W'(LAT);
      pendState <= runState_e'(wrCode);
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
      if (waitCnt == CNT_W'(1)) validQ <= 1'b1;
    end
  end

  always_comb begin
    strobes.ignore    = wrState && !swReset && !(validQ && legalCode);
    strobes.commit    = (waitCnt == CNT_W'(1)) && !swReset;
    strobes.newState  = pendState;
    strobes.swRst     = swReset;
    strobes.clrBusErr = accept && (wrCode == 2'b00);
  end

  assign validOut = validQ;
endmodule

// File: rtl/runstate_dp.sv
module runstate_dp
  import runstate_pkg::*;
#(
  parameter int ERR_W = 5,
  parameter int IGN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic             cfgDone,
  input  logic [ERR_W-1:0] errSet,
  input  logic             errClrWe,
  input  logic [ERR_W-1:0] errClrData,
  input  logic             byteBusy,
  output runState_e        curState,
  output logic             masterRdy,
  output logic [ERR_W-1:0] errFlags,
  output logic [IGN_W-1:0] ignCnt,
  output logic             takeEn,
  output logic             shiftEn,
  output logic             flushPulse,
  output logic             busClrPulse
);
  logic [ERR_W-1:0] clrMask;

  assign clrMask = errClrWe ? errClrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState    <= ST_RESET;
      masterRdy   <= 1'b0;
      errFlags    <= '0;
      ignCnt      <= '0;
      flushPulse  <= 1'b0;
      busClrPulse <= 1'b0;
    end else begin
      flushPulse  <= strobes.swRst;
      busClrPulse <= strobes.clrBusErr;
      if (strobes.swRst) begin
        curState  <= ST_RESET;
        masterRdy <= 1'b0;
        errFlags  <= '0;
        ignCnt    <= '0;
      end else begin
        if (strobes.commit) curState <= strobes.newState;
        if (cfgDone) masterRdy <= 1'b1;
        errFlags <= (errFlags & ~clrMask) | errSet;
        if (strobes.ignore && (ignCnt != {IGN_W{1'b1}})) ignCnt <= ignCnt + 1'b1;
      end
    end
  end

  assign takeEn  = (curState == ST_RUN);
  assign shiftEn = (curState == ST_RUN) || ((curState == ST_PAUSE) && byteBusy);
endmodule

// File: rtl/runstate_ctrl.sv
module runstate_ctrl
  import runstate_pkg::*;
#(
  parameter int SYNC_BUS   = 3,
  parameter int SYNC_CORE  = 3,
  parameter int CORE_RATIO = 2,
  parameter int ERR_W      = 5,
  parameter int IGN_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrState,
  input  logic [1:0]       wrCode,
  input  logic             swReset,
  input  logic             cfgDone,
  input  logic [ERR_W-1:0] errSet,
  input  logic             errClrWe,
  input  logic [ERR_W-1:0] errClrData,
  input  logic             byteBusy,
  output logic [4:0]       stateStatus,
  output logic [ERR_W+1:0] errStatus,
  output logic [IGN_W-1:0] ignCount,
  output logic             takeEn,
  output logic             shiftEn,
  output logic             queueFlush,
  output logic             busErrClr
);
  ctlStrobes_t      strobes;
  logic             validFlag;
  runState_e        curState;
  logic             masterRdy;
  logic [ERR_W-1:0] errFlags;

  runstate_ctl #(
    .SYNC_BUS(SYNC_BUS), .SYNC_CORE(SYNC_CORE), .CORE_RATIO(CORE_RATIO)
  ) i_ctl (
    .clk(clk), .rstN(rstN), .wrState(wrState), .wrCode(wrCode),
    .swReset(swReset), .validOut(validFlag), .strobes(strobes)
  );

  runstate_dp #(.ERR_W(ERR_W), .IGN_W(IGN_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgDone(cfgDone),
    .errSet(errSet), .errClrWe(errClrWe), .errClrData(errClrData),
    .byteBusy(byteBusy), .curState(curState), .masterRdy(masterRdy),
    .errFlags(errFlags), .ignCnt(ignCount), .takeEn(takeEn),
    .shiftEn(shiftEn), .flushPulse(queueFlush), .busClrPulse(busErrClr)
  );

  assign stateStatus = {masterRdy, 1'b0, validFlag, curState};
  assign errStatus   = {errFlags, 2'b00};
endmodule

// File: rtl/runstate_chk.sv
module runstate_chk #(
  parameter int SYNC_BUS   = 3,
  parameter int SYNC_CORE  = 3,
  parameter int CORE_RATIO = 2,
  parameter int ERR_W      = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrState,
  input logic [1:0]       wrCode,
  input logic             swReset,
  input logic [ERR_W-1:0] errSet,
  input logic             errClrWe,
  input logic [ERR_W-1:0] errClrData,
  input logic [4:0]       stateStatus,
  input logic [ERR_W+1:0] errStatus
);
  localparam int LAT = SYNC_BUS + SYNC_CORE * CORE_RATIO;

  logic       vld;
  logic       mrdy;
  logic [1:0] st;
  logic [7:0] lowCnt;

  assign vld  = stateStatus[2];
  assign mrdy = stateStatus[4];
  assign st   = stateStatus[1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowCnt <= '0;
    else if (vld) lowCnt <= '0;
    else if (lowCnt != 8'hFF) lowCnt <= lowCnt + 1'b1;
  end

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (wrState && vld && wrCode != 2'b10 && !swReset) |=> !vld); // R2

  AST_STATE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!vld && !swReset) |=> ($stable(st) || vld)); // R3

  AST_LATENCY_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    (!vld && !swReset && lowCnt == 8'(LAT - 1)) |=> vld); // R3

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (!vld && !swReset && lowCnt < 8'(LAT - 1)) |=> !vld); // R3

  AST_MASTER_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (mrdy && !swReset) |=> mrdy); // R4

  AST_SWRST_STATE: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> (st == 2'b00 && vld && !mrdy && errStatus == '0)); // R5

  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (errClrWe && !swReset) |=>
      ((errStatus[ERR_W+1:2] & $past(errClrData & ~errSet)) == '0)); // R6
endmodule

bind runstate_ctrl runstate_chk #(
  .SYNC_BUS(SYNC_BUS), .SYNC_CORE(SYNC_CORE), .CORE_RATIO(CORE_RATIO), .ERR_W(ERR_W)
) i_chk (
  .clk(clk), .rstN(rstN), .wrState(wrState), .wrCode(wrCode), .swReset(swReset),
  .errSet(errSet), .errClrWe(errClrWe), .errClrData(errClrData),
  .stateStatus(stateStatus), .errStatus(errStatus)
);

// File: tb/test_runstate_ctrl.sv
`timescale 1ns/1ps
module test_runstate_ctrl;
  localparam int LAT = 9;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrState = 1'b0;
  logic [1:0] wrCode = 2'b00;
  logic       swReset = 1'b0;
  logic       cfgDone = 1'b0;
  logic [4:0] errSet = '0;
  logic       errClrWe = 1'b0;
  logic [4:0] errClrData = '0;
  logic       byteBusy = 1'b0;
  logic [4:0] stateStatus;
  logic [6:0] errStatus;
  logic [7:0] ignCount;
  logic       takeEn, shiftEn, queueFlush, busErrClr;

  int checks = 0;
  int errors = 0;
  logic [1:0] expQ[$];
  int lowCnt = 0;

  always #2.5 clk = ~clk;

  runstate_ctrl i_runstate_ctrl (
    .clk(clk), .rstN(rstN), .wrState(wrState), .wrCode(wrCode),
    .swReset(swReset), .cfgDone(cfgDone), .errSet(errSet),
    .errClrWe(errClrWe), .errClrData(errClrData), .byteBusy(byteBusy),
    .stateStatus(stateStatus), .errStatus(errStatus), .ignCount(ignCount),
    .takeEn(takeEn), .shiftEn(shiftEn), .queueFlush(queueFlush),
    .busErrClr(busErrClr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops the expected committed state when valid returns (R3)
  always @(negedge clk) begin
    if (rstN) begin
      if (!stateStatus[2]) lowCnt++;
      else begin
        if (lowCnt != 0 && expQ.size() != 0) begin
          logic [1:0] e;
          e = expQ.pop_front();
          check("R3 committed state", stateStatus[1:0], e);
          check("R3 valid low window", lowCnt, LAT);
        end
        lowCnt = 0;
      end
    end
  end

  // Driver: one-cycle request; pushes the expected state if it should be accepted
  task automatic request(input logic [1:0] code, input bit expectAccept, output bit sawClr);
    @(posedge clk); #1;
    wrState = 1'b1; wrCode = code;
    if (expectAccept) expQ.push_back(code);
    @(posedge clk); #1;
    wrState = 1'b0;
    @(negedge clk);
    sawClr = busErrClr;
  endtask

  task automatic waitValid();
    while (!stateStatus[2]) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit clr;
    idle(2);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 state", stateStatus[1:0], 0);
    check("R1 valid", stateStatus[2], 1);
    check("R1 master", stateStatus[4], 0);
    check("R1 errors", errStatus, 0);
    check("R1 ignored count", ignCount, 0);
    check("R1 engine enables", {takeEn, shiftEn}, 0);

    // R2 accepted run request drops valid
    request(2'd1, 1'b1, clr);
    check("R2 valid low after accept", stateStatus[2], 0);
    check("R9 no clear for run request", clr, 0);
    check("R3 state held while pending", stateStatus[1:0], 0);
    waitValid();
    check("R7 run take enable", takeEn, 1);
    check("R7 run shift enable", shiftEn, 1);

    // R8 request while pending is refused
    request(2'd3, 1'b1, clr);
    request(2'd0, 1'b0, clr);
    check("R8 count after pending write", ignCount, 1);
    check("R9 refused reset gives no clear", clr, 0);
    waitValid();
    check("R8 refused write lost", stateStatus[1:0], 3);
    idle(1);
    check("R7 pause take enable", takeEn, 0);
    byteBusy = 1'b1;
    #0.1;
    check("R7 pause shift with byte busy", shiftEn, 1);
    byteBusy = 1'b0;
    #0.1;
    check("R7 pause shift idle", shiftEn, 0);

    // R8 illegal code refused
    request(2'd2, 1'b0, clr);
    check("R8 illegal code valid kept", stateStatus[2], 1);
    check("R8 illegal code state kept", stateStatus[1:0], 3);
    check("R8 count after illegal code", ignCount, 2);

    // R9 reset request pulses bus-error clear
    request(2'd0, 1'b1, clr);
    check("R9 clear pulse on reset request", clr, 1);
    @(negedge clk);
    check("R9 clear pulse one cycle", busErrClr, 0);
    waitValid();
    check("R7 reset enables", {takeEn, shiftEn}, 0);

    // R4 sticky master-ready
    @(posedge clk); #1 cfgDone = 1'b1;
    @(posedge clk); #1 cfgDone = 1'b0;
    @(negedge clk);
    check("R4 master set", stateStatus[4], 1);
    idle(5);
    check("R4 master sticky", stateStatus[4], 1);

    // R6 error flags
    @(posedge clk); #1 errSet = 5'b10101;
    @(posedge clk); #1 errSet = 5'b00000;
    @(negedge clk);
    check("R6 flags set", errStatus, 7'b1010100);
    @(posedge clk); #1 errClrWe = 1'b1; errClrData = 5'b00001;
    @(posedge clk); #1 errClrWe = 1'b0; errClrData = '0;
    @(negedge clk);
    check("R6 clear by one", errStatus, 7'b1010000);
    @(posedge clk); #1 errClrWe = 1'b1; errClrData = 5'b00010; errSet = 5'b00010;
    @(posedge clk); #1 errClrWe = 1'b0; errClrData = '0; errSet = '0;
    @(negedge clk);
    check("R6 set wins over clear", errStatus, 7'b1011000);

    // R5 software reset aborts pending run
    request(2'd1, 1'b0, clr);
    request(2'd3, 1'b0, clr);
    check("R8 count before reset", ignCount, 3);
    @(posedge clk); #1 swReset = 1'b1;
    @(posedge clk); #1 swReset = 1'b0;
    @(negedge clk);
    check("R5 flush pulse", queueFlush, 1);
    check("R5 state", stateStatus[1:0], 0);
    check("R5 valid", stateStatus[2], 1);
    check("R5 master cleared", stateStatus[4], 0);
    check("R5 errors cleared", errStatus, 0);
    check("R5 count cleared", ignCount, 0);
    idle(LAT + 2);
    check("R5 pending run aborted", stateStatus[1:0], 0);
    check("R5 flush pulse ended", queueFlush, 0);
    check("R3 monitor queue drained", expQ.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule